// File: doc/BRIEF.md
# Read Completion Timeout Tracker

This block sits beside a DMA engine that issues upstream memory read requests, each identified by a tag. When a request leaves, the engine records its tag and the number of bytes it asked for. Every incoming completion is then looked up by tag. A completion for a live tag is passed on as data, and its payload length is subtracted from the bytes still owed. The tag is retired when nothing is owed any more.

Each live tag carries a timer that advances on a shared prescaled tick. A tag still outstanding when its timer reaches the programmed limit is released and reported for abort or retry. The report is a completion-timeout error, fatal or non-fatal according to a configuration input. The tracker keeps the only authoritative list of live tags. A completion that matches no live tag is therefore blocked from the data path and flagged as unexpected. This includes a completion that arrives late for a tag already timed out. A completion carrying more bytes than the request still owes is blocked and flagged as malformed.

Top module: `rd_cpl_tracker`

## Requirements
- R1: After reset no tag is live, `req_ready` is 1 for every tag value and all report outputs are 0.
- R2: A request is taken only when `req_ready` is 1, which holds exactly when the tag on `req_tag` is not live. A request to a live tag is ignored: its owed byte count and its timer keep their values.
- R3: A completion to a live tag with `cpl_bytes` no larger than the bytes still owed raises `cpl_accept` in the same cycle and reduces the owed count. When the owed count reaches zero, `cpl_done` pulses for one cycle after that completion and the tag becomes free.
- R4: A completion to a tag that is not live gives `cpl_accept` = 0 and a one-cycle `err_unexp` pulse in the next cycle, and changes no tag state.
- R5: A completion whose `cpl_bytes` exceeds the bytes still owed gives `cpl_accept` = 0 and a one-cycle `err_malf` pulse in the next cycle, and frees the tag.
- R6: A tag whose timer, counting prescaled ticks of PRESCALE clocks, reaches the timeout value is released. `to_valid` pulses with that tag on `to_tag`, between (T-1)*PRESCALE and (T+1)*PRESCALE+3 cycles after the request, where T is the timeout value.
- R7: On each timeout exactly one of `to_fatal` and `to_nonfatal` is 1, chosen by `cfg_fatal` (1 selects fatal). Both are 0 when `to_valid` is 0.
- R8: A completion that arrives for a tag after that tag has timed out is treated as unexpected (R4).
- R9: When several tags expire in the same cycle, one timeout is reported per cycle, the lowest tag number first.
- R10: The timeout value resets to TMO_RST ticks and is loaded from `cfg_tmo` in the cycle where `cfg_we` is 1. A lowered value applies to requests already outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the timeout register |
| cfg_tmo | input | TMRW | New timeout value in ticks |
| cfg_fatal | input | 1 | 1: timeouts are reported as fatal |
| req_valid | input | 1 | Read request issued |
| req_tag | input | TAGW | Tag of the request |
| req_bytes | input | CNTW | Bytes requested (nonzero) |
| req_ready | output | 1 | Tag on `req_tag` is free |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | TAGW | Tag of the completion |
| cpl_bytes | input | CNTW | Payload length of the completion |
| cpl_accept | output | 1 | Completion is delivered as data |
| cpl_done | output | 1 | A request has received all its data |
| err_unexp | output | 1 | Completion with no live tag |
| err_malf | output | 1 | Completion overran the owed count |
| to_valid | output | 1 | A tag timed out |
| to_tag | output | TAGW | Tag that timed out |
| to_fatal | output | 1 | Timeout reported as fatal |
| to_nonfatal | output | 1 | Timeout reported as non-fatal |

## Verification
Completions are applied as a split into two partial payloads, as a single exact payload after a rejected re-issue, as a payload larger than owed and as a payload to a free tag. These cases separate the decrement path, the guard against overwriting a live entry, overrun detection and tag filtering. Timeouts are driven with the reset value and with a written value under both severity settings, and each is followed by a late completion. This shows that the timer window, the severity choice and the release of the tag all act. Two tags forced to expire together by lowering the limit show the one-per-cycle, lowest-first order of reports.

// File: rtl/rd_cpl_tracker.sv
module rd_cpl_tracker #(
  parameter int NTAG     = 32,
  parameter int LENW     = 12,
  parameter int TMRW     = 16,
  parameter int PRESCALE = 25000,
  parameter int TMO_RST  = 100,
  localparam int TAGW = $clog2(NTAG),
  localparam int CNTW = LENW + 1,
  localparam int PSW  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [TMRW-1:0] cfg_tmo,
  input  logic            cfg_fatal,
  input  logic            req_valid,
  input  logic [TAGW-1:0] req_tag,
  input  logic [CNTW-1:0] req_bytes,
  output logic            req_ready,
  input  logic            cpl_valid,
  input  logic [TAGW-1:0] cpl_tag,
  input  logic [CNTW-1:0] cpl_bytes,
  output logic            cpl_accept,
  output logic            cpl_done,
  output logic            err_unexp,
  output logic            err_malf,
  output logic            to_valid,
  output logic [TAGW-1:0] to_tag,
  output logic            to_fatal,
  output logic            to_nonfatal
);

  logic [NTAG-1:0] vld;
  logic [CNTW-1:0] rem [NTAG];
  logic [TMRW-1:0] tmr [NTAG];
  logic [TMRW-1:0] tmo_q;
  logic [PSW-1:0]  pcnt;
  logic            tick;
  logic [NTAG-1:0] expired;
  logic [TAGW-1:0] sel;
  logic            any_exp;
  logic            cpl_hit, cpl_over, cpl_last;

  assign tick = (pcnt == PSW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NTAG; i++) expired[i] = vld[i] && (tmr[i] >= tmo_q);
  end

  always_comb begin
    sel = '0;
    any_exp = 1'b0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (expired[i]) begin
        sel = TAGW'(i);
        any_exp = 1'b1;
      end
    end
  end

  assign req_ready  = !vld[req_tag];
  assign cpl_hit    = vld[cpl_tag] && !expired[cpl_tag];
  assign cpl_over   = cpl_bytes > rem[cpl_tag];
  assign cpl_last   = cpl_bytes == rem[cpl_tag];
  assign cpl_accept = cpl_valid && cpl_hit && !cpl_over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= '0;
      tmo_q       <= TMRW'(TMO_RST);
      cpl_done    <= 1'b0;
      err_unexp   <= 1'b0;
      err_malf    <= 1'b0;
      to_valid    <= 1'b0;
      to_tag      <= '0;
      to_fatal    <= 1'b0;
      to_nonfatal <= 1'b0;
      for (int i = 0; i < NTAG; i++) begin
        rem[i] <= '0;
        tmr[i] <= '0;
      end
    end else begin
      cpl_done    <= 1'b0;
      err_unexp   <= 1'b0;
      err_malf    <= 1'b0;
      to_valid    <= 1'b0;
      to_fatal    <= 1'b0;
      to_nonfatal <= 1'b0;
      if (cfg_we) tmo_q <= cfg_tmo;
      for (int i = 0; i < NTAG; i++) begin
        if (tick && vld[i] && !expired[i]) tmr[i] <= tmr[i] + 1'b1;
      end
      if (req_valid && req_ready) begin
        vld[req_tag] <= 1'b1;
        rem[req_tag] <= req_bytes;
        tmr[req_tag] <= '0;
      end
      if (cpl_valid) begin
        if (!cpl_hit) begin
          err_unexp <= 1'b1;
        end else if (cpl_over) begin
          err_malf <= 1'b1;
          vld[cpl_tag] <= 1'b0;
        end else if (cpl_last) begin
          cpl_done <= 1'b1;
          vld[cpl_tag] <= 1'b0;
          rem[cpl_tag] <= '0;
        end else begin
          rem[cpl_tag] <= rem[cpl_tag] - cpl_bytes;
        end
      end
      if (any_exp) begin
        vld[sel]    <= 1'b0;
        to_valid    <= 1'b1;
        to_tag      <= sel;
        to_fatal    <= cfg_fatal;
        to_nonfatal <= !cfg_fatal;
      end
    end
  end

  a_r2_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> vld[$past(req_tag)]);

  a_r3_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_done |-> $past(cpl_accept));

  a_r4_unexp_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    err_unexp |-> ($past(cpl_valid) && !$past(cpl_accept)));

  a_r5_malf_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    err_malf |-> ($past(cpl_valid) && !$past(cpl_accept)));

  a_r6_timeout_frees_tag: assert property (@(posedge clk) disable iff (!rst_n)
    to_valid |-> !vld[to_tag]);

  a_r7_one_severity: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({to_fatal, to_nonfatal}) == (to_valid ? 1 : 0));

endmodule

// File: tb/test_rd_cpl_tracker.sv
module test_rd_cpl_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NTAG = 32, LENW = 12, TMRW = 16, P = 4, TRST = 20;
  localparam int TAGW = $clog2(NTAG), CNTW = LENW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_fatal = 0, req_valid = 0, cpl_valid = 0;
  logic [TMRW-1:0] cfg_tmo = '0;
  logic [TAGW-1:0] req_tag = '0, cpl_tag = '0, to_tag;
  logic [CNTW-1:0] req_bytes = '0, cpl_bytes = '0;
  logic req_ready, cpl_accept, cpl_done, err_unexp, err_malf, to_valid, to_fatal, to_nonfatal;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_cpl_tracker #(.NTAG(NTAG), .LENW(LENW), .TMRW(TMRW), .PRESCALE(P), .TMO_RST(TRST)) i_rd_cpl_tracker (
    .clk, .rst_n, .cfg_we, .cfg_tmo, .cfg_fatal, .req_valid, .req_tag, .req_bytes, .req_ready,
    .cpl_valid, .cpl_tag, .cpl_bytes, .cpl_accept, .cpl_done, .err_unexp, .err_malf,
    .to_valid, .to_tag, .to_fatal, .to_nonfatal);

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(int tag, int bytes);
    req_valid = 1; req_tag = TAGW'(tag); req_bytes = CNTW'(bytes);
    step(); req_valid = 0;
  endtask

  task automatic cpl(string req, int tag, int bytes, int exp_acc, int exp_done, int exp_unexp, int exp_malf);
    cpl_valid = 1; cpl_tag = TAGW'(tag); cpl_bytes = CNTW'(bytes);
    #1 check({req, " accept"}, int'(cpl_accept), exp_acc);
    step(); cpl_valid = 0;
    check({req, " done"}, int'(cpl_done), exp_done);
    check({req, " unexp"}, int'(err_unexp), exp_unexp);
    check({req, " malf"}, int'(err_malf), exp_malf);
  endtask

  task automatic ready_of(string req, int tag, int exp);
    req_tag = TAGW'(tag);
    #1 check(req, int'(req_ready), exp);
  endtask

  task automatic wait_timeout(string req, int tmo, int tag, int fatal);
    int n = 0;
    while (!to_valid && n < 1000) begin step(); n++; end
    check({req, " window low"}, int'(n >= (tmo - 1) * P), 1);
    check({req, " window high"}, int'(n <= (tmo + 1) * P + 3), 1);
    check({req, " tag"}, int'(to_tag), tag);
    check({req, " fatal"}, int'(to_fatal), fatal);
    check({req, " nonfatal"}, int'(to_nonfatal), 1 - fatal);
    step();
  endtask

  task automatic t_reset();
    ready_of("R1 ready tag0", 0, 1);
    ready_of("R1 ready tag31", 31, 1);
    check("R1 outputs idle", int'({cpl_done, err_unexp, err_malf, to_valid, to_fatal, to_nonfatal}), 0);
  endtask

  task automatic t_split();
    issue(5, 256);
    ready_of("R2 tag5 busy", 5, 0);
    cpl("R3 part1", 5, 64, 1, 0, 0, 0);
    ready_of("R3 tag5 still busy", 5, 0);
    cpl("R3 part2", 5, 192, 1, 1, 0, 0);
    ready_of("R3 tag5 freed", 5, 1);
  endtask

  task automatic t_busy_ignored();
    issue(6, 100);
    repeat (10) step();
    ready_of("R2 tag6 busy", 6, 0);
    issue(6, 8);
    cpl("R2 reissue ignored", 6, 100, 1, 1, 0, 0);
  endtask

  task automatic t_unexp();
    cpl("R4 free tag", 9, 16, 0, 0, 1, 0);
    ready_of("R4 no state change", 9, 1);
    step();
    check("R4 pulse ends", int'(err_unexp), 0);
  endtask

  task automatic t_overrun();
    issue(10, 32);
    cpl("R5 overrun", 10, 48, 0, 0, 0, 1);
    ready_of("R5 tag freed", 10, 1);
  endtask

  task automatic t_timeouts();
    cfg_fatal = 0;
    issue(12, 64);
    wait_timeout("R6 R10 reset limit nonfatal R7", TRST, 12, 0);
    cpl("R8 late cpl", 12, 64, 0, 0, 1, 0);
    cfg_we = 1; cfg_tmo = TMRW'(5); step(); cfg_we = 0;
    cfg_fatal = 1;
    issue(13, 64);
    wait_timeout("R10 written limit fatal R7", 5, 13, 1);
    cpl("R8 late cpl fatal", 13, 8, 0, 0, 1, 0);
    cfg_fatal = 0;
  endtask

  task automatic t_order();
    cfg_we = 1; cfg_tmo = TMRW'(100); step(); cfg_we = 0;
    issue(7, 16);
    issue(3, 16);
    repeat (20) step();
    check("R9 none yet", int'(to_valid), 0);
    cfg_we = 1; cfg_tmo = TMRW'(1); step(); cfg_we = 0;
    step();
    check("R9 first valid", int'(to_valid), 1);
    check("R9 first tag", int'(to_tag), 3);
    step();
    check("R9 second valid", int'(to_valid), 1);
    check("R9 second tag", int'(to_tag), 7);
    step();
    check("R9 done", int'(to_valid), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_split();
    t_busy_ignored();
    t_unexp();
    t_overrun();
    t_timeouts();
    t_order();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule